// File: doc/BRIEF.md
# Raw NAND Command-Cycle Sequencer

The sequencer accepts one flash request at a time and plays it out on a raw NAND pin bus as a series of latch cycles. A request names an opcode and may carry a 16-bit column and a 24-bit page. The opcode selects an entry in a built-in format table. The entry gives the second command byte if there is one, the number of address bytes and whether the data phase that follows reads or writes. The block sends the opcode with CLE high, then the address bytes with ALE high, then the optional second command. It then waits for the device's ready/busy line to show ready and ends the request with a one-cycle done pulse and its status bits.

Multi-step operations keep the device selected between their halves. The request that confirms a program or an erase does not drop chip-select at its start, so the device sees one continuous selection from the setup half through the confirm half. Chip-select is released after the operations that finish a device action, and after a timeout. An out-of-band read request is turned into a page read with its column moved past the page data area. Software-side data transfers are not part of this block.

Top module: `nand_cmd_seq`

## Requirements
- R1: Each request emits its first command byte, then N address bytes, then the second command byte if the format has one. The formats are opcode/second command/N: 00/30/5, 05/E0/2, 90/-/1, 70/-/0, 80/-/5, 10/-/0, 15/-/0, 85/-/2, 60/-/3, D0/-/0, FF/-/0, EC/-/1, EE/-/1, EF/-/1 (hex).
- R2: The address bytes are drawn from this list, in order. With a column, the list is column[7:0], column[15:8], page[7:0], page[15:8], page[23:16], and the page bytes count as zero when there is no page. With a page and no column, the list is page[7:0], page[15:8], page[23:16]. The first N entries are sent, and missing entries are zero.
- R3: Opcode 0x50 (out-of-band read) is sent exactly as opcode 0x00 with column plus PAGE_BYTES (default 2048).
- R4: Every latch cycle has exactly one of CLE (command byte) and ALE (address byte) high, never both. nand_io carries the byte of that cycle.
- R5: Each latch cycle holds nand_we_n low for max(1, we_low_cyc) clocks. Inside a request, consecutive cycles are separated by max(1, we_high_cyc) clocks of nand_we_n high.
- R6: A request with opcode 0x10, 0x15 or 0xD0 drives nand_ce_n low from acceptance onward without a high clock. Any other request drives nand_ce_n high for at least one clock after acceptance before its first cycle. nand_we_n is low only while nand_ce_n is low.
- R7: After the last cycle the block waits for nand_rb_n = 1. A request that is not timed out completes only after nand_rb_n has been sampled high.
- R8: After a successful completion nand_ce_n is high for opcodes 0x10, 0x15, 0xD0 and 0xFF, and stays low for all others.
- R9: If nand_rb_n stays low for rdy_tmo_cyc+1 clocks of the wait, the request completes with timed_out = 1 and nand_ce_n high.
- R10: An opcode not in the table is sent as a single command cycle with no address cycles, and unknown_op = 1 at its completion.
- R11: done is a one-clock pulse. req_ready is high only while idle, and the bus is quiet then. A request presented while req_ready is low is ignored, so it produces no cycles and no done.
- R12: At completion dir_read is 1 for opcodes 00, 05, 90, 70, EC, EE and 50, and 0 otherwise. timed_out, unknown_op and dir_read hold until the next completion. All three reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | High while idle; request accepted when both high |
| req_op | input | 8 | Request opcode |
| req_has_col | input | 1 | Column field present |
| req_col | input | 16 | Column address |
| req_has_page | input | 1 | Page field present |
| req_page | input | 24 | Page address |
| we_low_cyc | input | CNT_W | Write-enable low time in clocks (0 acts as 1) |
| we_high_cyc | input | CNT_W | Write-enable high time in clocks (0 acts as 1) |
| rdy_tmo_cyc | input | TMO_W | Ready-wait limit |
| done | output | 1 | One-clock completion pulse |
| timed_out | output | 1 | Last request ended by timeout |
| unknown_op | output | 1 | Last request used an opcode outside the table |
| dir_read | output | 1 | Last request's data phase is a read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_io | output | 8 | Command/address byte |
| nand_rb_n | input | 1 | Ready (1) / busy (0) |

## Verification
The hardest case to reach is the confirm half of a split operation. Chip-select must reach it still asserted from the setup half and must not blink at its start. The bench gets there by pairing a serial-input or erase-setup request directly with its confirm, and by mixing confirm opcodes freely into a long random request stream. In that stream the prior chip-select state varies, including the released state left by a timeout. The ready wait is covered the same way: the bench model holds busy longer than the whole cycle sequence, and in one case forever.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int PAGE_BYTES = 2048,
  parameter int CNT_W = 4,
  parameter int TMO_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_op,
  input  logic             req_has_col,
  input  logic [15:0]      req_col,
  input  logic             req_has_page,
  input  logic [23:0]      req_page,
  input  logic [CNT_W-1:0] we_low_cyc,
  input  logic [CNT_W-1:0] we_high_cyc,
  input  logic [TMO_W-1:0] rdy_tmo_cyc,
  output logic             done,
  output logic             timed_out,
  output logic             unknown_op,
  output logic             dir_read,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic [7:0]       nand_io,
  input  logic             nand_rb_n
);

  typedef enum logic [2:0] {S_IDLE, S_CEOFF, S_LOW, S_HIGH, S_WAIT} state_t;

  typedef struct packed {
    logic       known;
    logic       rd;
    logic       has_end;
    logic [7:0] endc;
    logic [2:0] na;
  } fmt_t;

  function automatic fmt_t lookup(input logic [7:0] op);
    fmt_t f;
    f = '{known: 1'b1, rd: 1'b0, has_end: 1'b0, endc: 8'h00, na: 3'd0};
    case (op)
      8'h00: begin f.rd = 1'b1; f.has_end = 1'b1; f.endc = 8'h30; f.na = 3'd5; end
      8'h05: begin f.rd = 1'b1; f.has_end = 1'b1; f.endc = 8'hE0; f.na = 3'd2; end
      8'h90: begin f.rd = 1'b1; f.na = 3'd1; end
      8'h70: f.rd = 1'b1;
      8'h80: f.na = 3'd5;
      8'h10, 8'h15, 8'hD0, 8'hFF: f.na = 3'd0;
      8'h85: f.na = 3'd2;
      8'h60: f.na = 3'd3;
      8'hEC: begin f.rd = 1'b1; f.na = 3'd1; end
      8'hEE: begin f.rd = 1'b1; f.na = 3'd1; end
      8'hEF: f.na = 3'd1;
      default: f.known = 1'b0;
    endcase
    return f;
  endfunction

  state_t           state;
  logic [7:0]       op_r;
  fmt_t             fmt_r;
  logic [39:0]      addr_r;
  logic             rel_r;
  logic [2:0]       step;
  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] tcnt;
  logic             ce_n_r, done_r, tmo_r, unk_r, dir_r;

  wire              is_oob   = (req_op == 8'h50);
  wire [7:0]        eff_op   = is_oob ? 8'h00 : req_op;
  wire [15:0]       eff_col  = req_col + (is_oob ? 16'(PAGE_BYTES) : 16'd0);
  wire              hold_op  = (eff_op == 8'h10) || (eff_op == 8'h15) || (eff_op == 8'hD0);
  wire              rel_op   = hold_op || (eff_op == 8'hFF);
  wire [39:0]       new_addr = req_has_col  ? {(req_has_page ? req_page : 24'h0), eff_col} :
                               req_has_page ? {16'h0, req_page} : 40'h0;
  fmt_t             nf;
  assign nf = lookup(eff_op);

  wire [CNT_W-1:0]  lo_lim    = (we_low_cyc  == '0) ? CNT_W'(1) : we_low_cyc;
  wire [CNT_W-1:0]  hi_lim    = (we_high_cyc == '0) ? CNT_W'(1) : we_high_cyc;
  wire [2:0]        last_step = fmt_r.na + {2'b00, fmt_r.has_end};
  wire [2:0]        aidx      = step - 3'd1;
  wire [39:0]       ashift    = addr_r >> {aidx, 3'b000};
  wire              in_cyc    = (state == S_LOW) || (state == S_HIGH);
  wire              is_addr   = (step != 3'd0) && (step <= fmt_r.na);
  wire [7:0]        cur_byte  = (step == 3'd0) ? op_r : (is_addr ? ashift[7:0] : fmt_r.endc);

  assign req_ready  = (state == S_IDLE);
  assign nand_cle   = in_cyc && !is_addr;
  assign nand_ale   = in_cyc && is_addr;
  assign nand_we_n  = (state != S_LOW);
  assign nand_io    = in_cyc ? cur_byte : 8'h00;
  assign nand_ce_n  = ce_n_r;
  assign done       = done_r;
  assign timed_out  = tmo_r;
  assign unknown_op = unk_r;
  assign dir_read   = dir_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_r   <= 8'h00;
      fmt_r  <= '0;
      addr_r <= '0;
      rel_r  <= 1'b0;
      step   <= 3'd0;
      cnt    <= '0;
      tcnt   <= '0;
      ce_n_r <= 1'b1;
      done_r <= 1'b0;
      tmo_r  <= 1'b0;
      unk_r  <= 1'b0;
      dir_r  <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op_r   <= eff_op;
          fmt_r  <= nf;
          addr_r <= new_addr;
          rel_r  <= rel_op;
          step   <= 3'd0;
          cnt    <= '0;
          tcnt   <= '0;
          if (hold_op) begin
            ce_n_r <= 1'b0;
            state  <= S_LOW;
          end else begin
            ce_n_r <= 1'b1;
            state  <= S_CEOFF;
          end
        end
        S_CEOFF: begin
          ce_n_r <= 1'b0;
          state  <= S_LOW;
        end
        S_LOW: if (cnt == lo_lim - CNT_W'(1)) begin
          cnt   <= '0;
          state <= S_HIGH;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        S_HIGH: if (cnt == hi_lim - CNT_W'(1)) begin
          cnt <= '0;
          if (step == last_step) begin
            state <= S_WAIT;
          end else begin
            step  <= step + 3'd1;
            state <= S_LOW;
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        S_WAIT: if (nand_rb_n || (tcnt == rdy_tmo_cyc)) begin
          state  <= S_IDLE;
          done_r <= 1'b1;
          tmo_r  <= !nand_rb_n;
          unk_r  <= !fmt_r.known;
          dir_r  <= fmt_r.rd;
          if (rel_r || !nand_rb_n) ce_n_r <= 1'b1;
        end else begin
          tcnt <= tcnt + TMO_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic timed_out,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_rb_n
);

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nand_cle && nand_ale)); // R4
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n) !nand_we_n |-> !nand_ce_n); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_ready |=> !req_ready); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> nand_we_n && !nand_cle && !nand_ale); // R11
  AST_OK_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n) done && !timed_out |-> $past(nand_rb_n)); // R7
  AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) done && timed_out |-> nand_ce_n); // R9

endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .timed_out(timed_out), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_rb_n(nand_rb_n)
);

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_op = 8'h00;
  logic req_has_col = 1'b0, req_has_page = 1'b0;
  logic [15:0] req_col = 16'h0;
  logic [23:0] req_page = 24'h0;
  logic [3:0] we_low_cyc = 4'd1, we_high_cyc = 4'd1;
  logic [15:0] rdy_tmo_cyc = 16'd1000;
  logic done, timed_out, unknown_op, dir_read;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n;
  logic [7:0] nand_io;
  logic nand_rb_n;

  int busy_left = 0;
  bit busy_forever = 1'b0;
  assign nand_rb_n = !(busy_forever || busy_left != 0);

  nand_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_has_col(req_has_col), .req_col(req_col),
    .req_has_page(req_has_page), .req_page(req_page),
    .we_low_cyc(we_low_cyc), .we_high_cyc(we_high_cyc), .rdy_tmo_cyc(rdy_tmo_cyc),
    .done(done), .timed_out(timed_out), .unknown_op(unknown_op), .dir_read(dir_read),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_io(nand_io), .nand_rb_n(nand_rb_n)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {known, rd, has_end, endc[7:0], na[2:0]}
  function automatic logic [13:0] bfmt(input logic [7:0] op);
    case (op)
      8'h00: return {3'b111, 8'h30, 3'd5};
      8'h05: return {3'b111, 8'hE0, 3'd2};
      8'h90: return {3'b110, 8'h00, 3'd1};
      8'h70: return {3'b110, 8'h00, 3'd0};
      8'h80: return {3'b100, 8'h00, 3'd5};
      8'h10: return {3'b100, 8'h00, 3'd0};
      8'h15: return {3'b100, 8'h00, 3'd0};
      8'h85: return {3'b100, 8'h00, 3'd2};
      8'h60: return {3'b100, 8'h00, 3'd3};
      8'hD0: return {3'b100, 8'h00, 3'd0};
      8'hFF: return {3'b100, 8'h00, 3'd0};
      8'hEC: return {3'b110, 8'h00, 3'd1};
      8'hEE: return {3'b110, 8'h00, 3'd1};
      8'hEF: return {3'b100, 8'h00, 3'd1};
      default: return {3'b000, 8'h00, 3'd0};
    endcase
  endfunction

  int cap_n = 0;
  int cap_kind [16];
  logic [7:0] cap_byte [16];
  always @(posedge nand_we_n) begin
    if (cap_n < 16) begin
      cap_kind[cap_n] = nand_cle ? (nand_ale ? 3 : 1) : (nand_ale ? 2 : 0);
      cap_byte[cap_n] = nand_io;
    end
    cap_n++;
  end

  bit mon_on = 1'b0, seen_rise = 1'b0, saw_ce_hi = 1'b0, we_prev = 1'b1;
  int lowcnt = 0, highcnt = 0, exp_lo = 1, exp_hi = 1;
  always @(negedge clk) begin
    cycles++;
    if (busy_left > 0) busy_left--;
    if (mon_on && !done) begin
      if (nand_ce_n) saw_ce_hi = 1'b1;
      if (!nand_we_n) begin
        if (we_prev && seen_rise) chk(highcnt == exp_hi, "R5 we high width", highcnt, exp_hi);
        if (we_prev) lowcnt = 0;
        lowcnt++;
      end else begin
        if (!we_prev) begin
          chk(lowcnt == exp_lo, "R5 we low width", lowcnt, exp_lo);
          seen_rise = 1'b1;
          highcnt = 0;
        end
        highcnt++;
      end
      we_prev = nand_we_n;
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_req(input logic [7:0] op, input bit hc, input logic [15:0] col,
                         input bit hp, input logic [23:0] page, input int lo, input int hi,
                         input int tmo, input int busy, input bit fbusy, input bit spam);
    logic [7:0] eop;
    logic [15:0] ecol;
    logic [13:0] f;
    logic [7:0] src [5];
    int en;
    int ek [8];
    logic [7:0] eb [8];
    bit hold, rel, ok_done;
    int wait_n;
    int cap_seen;
    eop  = (op == 8'h50) ? 8'h00 : op;
    ecol = col + ((op == 8'h50) ? 16'd2048 : 16'd0);
    f    = bfmt(eop);
    for (int i = 0; i < 5; i++) src[i] = 8'h00;
    if (hc) begin
      src[0] = ecol[7:0]; src[1] = ecol[15:8];
      if (hp) begin src[2] = page[7:0]; src[3] = page[15:8]; src[4] = page[23:16]; end
    end else if (hp) begin
      src[0] = page[7:0]; src[1] = page[15:8]; src[2] = page[23:16];
    end
    en = 0;
    ek[en] = 1; eb[en] = eop; en++;
    for (int i = 0; i < int'(f[2:0]); i++) begin ek[en] = 2; eb[en] = src[i]; en++; end
    if (f[11]) begin ek[en] = 1; eb[en] = f[10:3]; en++; end
    hold = (eop == 8'h10) || (eop == 8'h15) || (eop == 8'hD0);
    rel  = hold || (eop == 8'hFF);

    @(negedge clk);
    req_op = op; req_has_col = hc; req_col = col; req_has_page = hp; req_page = page;
    we_low_cyc = 4'(lo); we_high_cyc = 4'(hi); rdy_tmo_cyc = 16'(tmo);
    exp_lo = (lo == 0) ? 1 : lo;
    exp_hi = (hi == 0) ? 1 : hi;
    busy_forever = fbusy;
    busy_left = busy;
    cap_n = 0;
    req_valid = 1'b1;
    @(posedge clk);
    saw_ce_hi = 1'b0; seen_rise = 1'b0; we_prev = 1'b1; lowcnt = 0; highcnt = 0;
    mon_on = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (spam) begin
      req_op = 8'hFF;
      for (int i = 0; i < 3; i++) begin
        req_valid = 1'b1;
        chk(req_ready == 1'b0, "R11 ready low while busy", req_ready, 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    ok_done = 1'b0;
    wait_n = 0;
    while (!ok_done && wait_n < 5000) begin
      if (done) ok_done = 1'b1; else begin @(negedge clk); wait_n++; end
    end
    mon_on = 1'b0;
    chk(ok_done, "R11 done seen", ok_done, 1);
    chk(cap_n == en, "R1 cycle count", cap_n, en);
    for (int i = 0; i < en && i < cap_n && i < 16; i++) begin
      chk(cap_kind[i] == ek[i], "R4 cycle kind (1=cmd 2=addr)", cap_kind[i], ek[i]);
      chk(cap_byte[i] == eb[i], "R2 cycle byte", cap_byte[i], eb[i]);
    end
    chk(saw_ce_hi == !hold, "R6 ce toggle at start", saw_ce_hi, !hold);
    chk(timed_out == fbusy, "R9 timed_out", timed_out, fbusy);
    if (!fbusy) begin
      chk(nand_rb_n == 1'b1, "R7 ready before done", nand_rb_n, 1);
      chk(nand_ce_n == rel, "R8 ce after done", nand_ce_n, rel);
    end else begin
      chk(nand_ce_n == 1'b1, "R9 ce released on timeout", nand_ce_n, 1);
    end
    chk(unknown_op == !f[13], "R10 unknown_op", unknown_op, !f[13]);
    chk(dir_read == f[12], "R12 dir_read", dir_read, f[12]);
    cap_seen = cap_n;
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
    if (spam) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(done == 1'b0, "R11 ignored request gives no done", done, 0);
      end
      chk(cap_n == cap_seen, "R11 ignored request gives no cycles", cap_n, cap_seen);
    end
    busy_forever = 1'b0;
    busy_left = 0;
  endtask

  initial begin
    logic [7:0] ops [16];
    ops = '{8'h00, 8'h05, 8'h90, 8'h70, 8'h80, 8'h10, 8'h15, 8'h85,
            8'h60, 8'hD0, 8'hFF, 8'hEC, 8'hEE, 8'hEF, 8'h50, 8'h3C};
    void'($urandom(32'h5EED0123));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(nand_ce_n == 1'b1, "R6 reset ce_n", nand_ce_n, 1);
    chk(nand_we_n == 1'b1 && !nand_cle && !nand_ale, "R11 reset bus quiet", {nand_we_n, nand_cle, nand_ale}, 3'b100);
    chk(req_ready == 1'b1 && done == 1'b0, "R11 reset ready", {req_ready, done}, 2'b10);
    chk({timed_out, unknown_op, dir_read} == 3'b000, "R12 reset status", {timed_out, unknown_op, dir_read}, 0);

    run_req(8'h00, 1, 16'h1234, 1, 24'hABCDEF, 2, 1, 1000, 10, 0, 0);   // R1 R2
    run_req(8'h50, 1, 16'h0010, 1, 24'h000102, 1, 2, 1000, 0, 0, 0);    // R3
    run_req(8'h80, 1, 16'h0004, 1, 24'h445566, 3, 3, 1000, 0, 0, 0);    // R6 setup
    run_req(8'h10, 0, 16'h0000, 0, 24'h0, 1, 1, 1000, 20, 0, 0);        // R6 R8 hold
    run_req(8'h60, 0, 16'h0000, 1, 24'h778899, 0, 0, 1000, 0, 0, 0);    // R2 page only
    run_req(8'hD0, 0, 16'h0000, 0, 24'h0, 1, 1, 1000, 30, 0, 0);        // R8
    run_req(8'h05, 1, 16'hBEEF, 0, 24'h0, 4, 2, 1000, 0, 0, 0);         // R1
    run_req(8'hFF, 0, 16'h0000, 0, 24'h0, 1, 1, 1000, 60, 0, 0);        // R7
    run_req(8'h80, 1, 16'h0001, 1, 24'h000203, 1, 1, 5, 0, 1, 0);       // R9
    run_req(8'h10, 0, 16'h0000, 0, 24'h0, 1, 1, 1000, 0, 0, 0);         // R6 hold after timeout
    run_req(8'h42, 1, 16'h5555, 1, 24'h666666, 2, 2, 1000, 0, 0, 0);    // R10
    run_req(8'h90, 0, 16'h0000, 1, 24'h000000, 1, 1, 1000, 0, 0, 1);    // R11
    run_req(8'h85, 1, 16'h0203, 1, 24'h111111, 2, 0, 1000, 0, 0, 0);    // R2 column only bytes

    for (int n = 0; n < 150; n++) begin
      logic [7:0] op;
      op = ops[$urandom_range(15)];
      if (op == 8'h3C) op = 8'(($urandom_range(2) == 0) ? 8'h3C : 8'hA7);
      run_req(op, 1'($urandom_range(1)), 16'($urandom), 1'($urandom_range(1)), 24'($urandom),
              int'($urandom_range(3)), int'($urandom_range(3)), 1000,
              int'($urandom_range(20)), 0, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule